// File: doc/BRIEF.md
# GPIO Pad Control and Port Unit

This block sits between a simple register bus and up to 64 general-purpose pads. Each pad owns a configuration word. That word selects what drives the pad: the GPIO output register or one of three alternate peripheral functions. The same word holds the pad's static electrical controls, which are the open-drain mode, the slew rate, the pull enable and direction, the analog switch enable and the safe-mode override. One write replaces the whole set.

Pad output data and pad input data live in two separate byte windows. The same bits can be reached with 8-, 16- or 32-bit accesses, and each width uses its own address inside the window. Every access completes in a single bus transaction. Input levels cross a two-flop synchroniser before the bus can read them. An external safe-mode signal turns off the output buffer of every pad whose safe-mode bit is set.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset every configuration word and every output data bit is zero. All pad_oe_o, pad_pull_en_o, pad_pull_up_o, pad_slew_o and pad_ana_en_o bits are 0, and rdata_o is 0.
- R2: A write to address 4*p (p < 64) stores wdata_i[8:0] as the configuration word of pad p, whatever size_i is. The bits are od_en [0], slew_fast [1], pull_en [2], pull_up [3], ana_en [4], safe_en [5], gpio_oe [6] and fsel [8:7]. A read of the same address returns the word zero-extended. A single write replaces every field at once.
- R3: When fsel is 0 (GPIO), pad_out_o[p] equals output data bit p and pad_oe_o[p] equals gpio_oe.
- R4: When fsel is k (1 to 3), pad_out_o[p] and pad_oe_o[p] follow alt_out_i[3*p+k-1] and alt_oe_i[3*p+k-1], and the other alternate inputs have no effect.
- R5: When od_en is set, pad_out_o[p] is 0. pad_oe_o[p] is the selected output enable AND NOT the selected data, so a logic 1 releases the pad.
- R6: While safe_i is 1, pad_oe_o[p] is 0 for every pad whose safe_en is set, whatever fsel is. Pads with safe_en clear are unaffected.
- R7: The output data window starts at 0x100 and the input window at 0x200. Byte offset b holds pads 8b to 8b+7, with pad 8b in bit 7. A 32-bit access (size_i = 2 or 3) at offset 0 or 4 places the byte at that offset in bits 31:24 and the byte at offset+3 in bits 7:0.
- R8: A 16-bit access (size_i = 1) reaches bytes at offset and offset+1 in bits 15:8 and 7:0. An 8-bit access (size_i = 0) reaches one byte in bits 7:0. Address bits below the access width are ignored. All widths reach the same storage.
- R9: Writes to the input window change neither the input data nor the output data.
- R10: A level applied to pad_in_i is first returned by a read that is issued on the third clock edge after the change. The reads captured on the first two edges still return the old level.
- R11: rdata_o is registered and updates on the edge that captures a read request (req_i=1, we_i=0). It keeps its value on every other cycle, including cycles with writes.
- R12: pad_slew_o, pad_pull_en_o, pad_pull_up_o and pad_ana_en_o of pad p follow slew_fast, pull_en, pull_up and ana_en of its configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Byte address |
| size_i | input | 2 | 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit |
| wdata_i | input | 32 | Write data, narrow widths in low bits |
| rdata_o | output | 32 | Registered read data |
| safe_i | input | 1 | Safe-mode request |
| pad_in_i | input | 64 | Asynchronous pad input levels |
| alt_out_i | input | 192 | Alternate function output data, 3 per pad |
| alt_oe_i | input | 192 | Alternate function output enables, 3 per pad |
| pad_out_o | output | 64 | Pad output data |
| pad_oe_o | output | 64 | Pad output buffer enable |
| pad_slew_o | output | 64 | Fast slew select |
| pad_pull_en_o | output | 64 | Pull resistor enable |
| pad_pull_up_o | output | 64 | Pull direction, 1 = up |
| pad_ana_en_o | output | 64 | Analog switch enable |

## Verification
The data windows are driven with asymmetric 32-bit patterns, then read back at 16-bit and 8-bit addresses and written in narrow and misaligned pieces. A swap of bytes, a reversal of bits within a byte or a wrong lane for a narrow access shows up as a mismatch, and the pad_out_o vector confirms which physical pad each bit reaches. The output mux is exercised in GPIO mode, in two alternate selections with decoy values on the unselected alternate inputs, with open-drain driving 0 and 1, and with safe mode on pads that do and do not opt in. These cases separate wrong selection from wrong gating. Back-to-back reads after an input change pin down the synchroniser depth exactly.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int ADDR_W  = 10;
  localparam int FSEL_W  = 2;
  localparam int NUM_ALT = (1 << FSEL_W) - 1;

  localparam logic [1:0] RGN_CFG  = 2'd0;
  localparam logic [1:0] RGN_DOUT = 2'd1;
  localparam logic [1:0] RGN_DIN  = 2'd2;

  typedef struct packed {
    logic [FSEL_W-1:0] fsel;
    logic              gpio_oe;
    logic              safe_en;
    logic              ana_en;
    logic              pull_up;
    logic              pull_en;
    logic              slew_fast;
    logic              od_en;
  } pad_cfg_t;

  localparam int CFG_W = $bits(pad_cfg_t);

  function automatic int acc_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_bus_regs.sv
module gpio_bus_regs
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PADS = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [1:0]            size_i,
  input  logic [31:0]           wdata_i,
  input  logic [NUM_PADS-1:0]   din_i,
  output logic [31:0]           rdata_o,
  output pad_cfg_t [NUM_PADS-1:0] cfg_o,
  output logic [NUM_PADS-1:0]   dout_o
);
  localparam int NB    = NUM_PADS / 8;
  localparam int OFF_W = $clog2(NB);
  localparam int IDX_W = $clog2(NUM_PADS);

  pad_cfg_t [NUM_PADS-1:0] cfg_q;
  logic [NUM_PADS-1:0] dout_q, dout_d;
  logic [31:0]         rd_d;
  logic [7:0]          dbyte [NB];
  logic [7:0]          ibyte [NB];
  logic [1:0]          rgn;
  logic [IDX_W-1:0]    idx;
  logic [OFF_W-1:0]    off;
  int                  nb, bs;

  assign rgn = addr_i[ADDR_W-1 -: 2];
  assign idx = addr_i[2 +: IDX_W];
  assign off = addr_i[OFF_W-1:0];

  // pad 8b sits in bit 7 of byte b
  always_comb begin
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < 8; i++) begin
        dbyte[b][7-i] = dout_q[8*b+i];
        ibyte[b][7-i] = din_i[8*b+i];
      end
    end
  end

  always_comb begin
    nb     = acc_bytes(size_i);
    bs     = int'(off) & ~(nb - 1);
    dout_d = dout_q;
    if (req_i && we_i && rgn == RGN_DOUT) begin
      for (int b = 0; b < NB; b++) begin
        if (b >= bs && b < bs + nb) begin
          for (int i = 0; i < 8; i++)
            dout_d[8*b+i] = wdata_i[8*(nb-1-(b-bs)) + 7 - i];
        end
      end
    end
    rd_d = '0;
    case (rgn)
      RGN_CFG: rd_d = 32'(cfg_q[idx]);
      RGN_DOUT, RGN_DIN: begin
        for (int j = 0; j < 4; j++) begin
          if (j < nb && bs + j < NB)
            rd_d[8*(nb-1-j) +: 8] = (rgn == RGN_DOUT) ? dbyte[bs+j] : ibyte[bs+j];
        end
      end
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      dout_q  <= '0;
      rdata_o <= '0;
    end else begin
      dout_q <= dout_d;
      if (req_i && we_i && rgn == RGN_CFG) cfg_q[idx] <= pad_cfg_t'(wdata_i[CFG_W-1:0]);
      if (req_i && !we_i) rdata_o <= rd_d;
    end
  end

  assign cfg_o  = cfg_q;
  assign dout_o = dout_q;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PADS = 64
) (
  input  pad_cfg_t [NUM_PADS-1:0]       cfg_i,
  input  logic [NUM_PADS-1:0]           dout_i,
  input  logic [NUM_PADS*NUM_ALT-1:0]   alt_out_i,
  input  logic [NUM_PADS*NUM_ALT-1:0]   alt_oe_i,
  input  logic                          safe_i,
  output logic [NUM_PADS-1:0]           pad_out_o,
  output logic [NUM_PADS-1:0]           pad_oe_o
);
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic [NUM_ALT-1:0] a_out, a_oe;
    logic d_sel, oe_sel;
    assign a_out = alt_out_i[p*NUM_ALT +: NUM_ALT];
    assign a_oe  = alt_oe_i[p*NUM_ALT +: NUM_ALT];

    always_comb begin
      if (cfg_i[p].fsel == '0) begin
        d_sel  = dout_i[p];
        oe_sel = cfg_i[p].gpio_oe;
      end else begin
        d_sel  = a_out[int'(cfg_i[p].fsel) - 1];
        oe_sel = a_oe[int'(cfg_i[p].fsel) - 1];
      end
      // open drain: a 1 releases the pad
      if (cfg_i[p].od_en) begin
        pad_out_o[p] = 1'b0;
        oe_sel       = oe_sel & ~d_sel;
      end else begin
        pad_out_o[p] = d_sel;
      end
      pad_oe_o[p] = oe_sel & ~(safe_i & cfg_i[p].safe_en);
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PADS = 64
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [1:0]                  size_i,
  input  logic [31:0]                 wdata_i,
  output logic [31:0]                 rdata_o,
  input  logic                        safe_i,
  input  logic [NUM_PADS-1:0]         pad_in_i,
  input  logic [NUM_PADS*NUM_ALT-1:0] alt_out_i,
  input  logic [NUM_PADS*NUM_ALT-1:0] alt_oe_i,
  output logic [NUM_PADS-1:0]         pad_out_o,
  output logic [NUM_PADS-1:0]         pad_oe_o,
  output logic [NUM_PADS-1:0]         pad_slew_o,
  output logic [NUM_PADS-1:0]         pad_pull_en_o,
  output logic [NUM_PADS-1:0]         pad_pull_up_o,
  output logic [NUM_PADS-1:0]         pad_ana_en_o
);
  pad_cfg_t [NUM_PADS-1:0] cfg;
  logic [NUM_PADS-1:0] dout, din_sync, safe_mask, od_mask;

  gpio_in_sync #(.W(NUM_PADS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_in_i), .q_o(din_sync)
  );

  gpio_bus_regs #(.NUM_PADS(NUM_PADS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .size_i(size_i), .wdata_i(wdata_i), .din_i(din_sync),
    .rdata_o(rdata_o), .cfg_o(cfg), .dout_o(dout)
  );

  gpio_pad_mux #(.NUM_PADS(NUM_PADS)) u_mux (
    .cfg_i(cfg), .dout_i(dout), .alt_out_i(alt_out_i), .alt_oe_i(alt_oe_i),
    .safe_i(safe_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_static
    assign pad_slew_o[p]    = cfg[p].slew_fast;
    assign pad_pull_en_o[p] = cfg[p].pull_en;
    assign pad_pull_up_o[p] = cfg[p].pull_up;
    assign pad_ana_en_o[p]  = cfg[p].ana_en;
    assign safe_mask[p]     = cfg[p].safe_en;
    assign od_mask[p]       = cfg[p].od_en;
  end
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk #(
  parameter int NUM_PADS = 64
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic                safe_i,
  input logic [31:0]         rdata_o,
  input logic [NUM_PADS-1:0] pad_in_i,
  input logic [NUM_PADS-1:0] din_sync,
  input logic [NUM_PADS-1:0] pad_out_o,
  input logic [NUM_PADS-1:0] pad_oe_o,
  input logic [NUM_PADS-1:0] safe_mask,
  input logic [NUM_PADS-1:0] od_mask
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  AST_SAFE_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    safe_i |-> ((pad_oe_o & safe_mask) == '0)); // R6

  AST_OD_NEVER_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & od_mask & pad_out_o) == '0)); // R5

  AST_OD_OUT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_out_o & od_mask) == '0)); // R5

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o)); // R11

  AST_SYNC_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (din_sync == $past(pad_in_i, 2))); // R10
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk #(.NUM_PADS(NUM_PADS)) u_chk (.*);

// File: tb/gpio_pad_ctrl_tb_top.sv
module gpio_pad_ctrl_tb_top;
  localparam int NP = 64;
  localparam int NA = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0, safe = 1'b0;
  logic [9:0] addr = '0;
  logic [1:0] size = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP*NA-1:0] alt_out = '0, alt_oe = '0;
  logic [NP-1:0] pout, poe, pslew, ppen, ppup, pana;
  logic [NP-1:0] exp_dout = '0;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_pad_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .safe_i(safe),
    .pad_in_i(pad_in), .alt_out_i(alt_out), .alt_oe_i(alt_oe),
    .pad_out_o(pout), .pad_oe_o(poe), .pad_slew_o(pslew),
    .pad_pull_en_o(ppen), .pad_pull_up_o(ppup), .pad_ana_en_o(pana)
  );

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] ebyte(input logic [63:0] v, input int b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = v[8*b+i];
    return r;
  endfunction

  function automatic logic [31:0] eword(input logic [63:0] v, input int b);
    return {ebyte(v, b), ebyte(v, b+1), ebyte(v, b+2), ebyte(v, b+3)};
  endfunction

  task automatic set_byte(input int b, input logic [7:0] d);
    for (int i = 0; i < 8; i++) exp_dout[8*b+i] = d[7-i];
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; size = s; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [9:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a; size = s;
    @(negedge clk);
    req = 0;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 oe", poe, '0);
    chk("R1 pull", ppen | ppup, '0);
    chk("R1 slew/ana", pslew | pana, '0);
    chk("R1 rdata", rdata, '0);
    bus_rd(10'h014, 2'd2, d); chk("R1 cfg5", d, '0);
    bus_rd(10'h100, 2'd2, d); chk("R1 dout", d, '0);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    bus_wr(10'h014, 2'd2, 32'h0000_01FF);
    bus_rd(10'h014, 2'd2, d); chk("R2 readback", d, 32'h1FF);
    chk("R12 slew", pslew[5], 1); chk("R12 pull_en", ppen[5], 1);
    chk("R12 pull_up", ppup[5], 1); chk("R12 ana", pana[5], 1);
    chk("R12 neighbour", {pslew[4], ppen[4], pana[6]}, 0);
    bus_wr(10'h014, 2'd0, 32'hFFFF_FE0C);
    bus_rd(10'h014, 2'd2, d); chk("R2 full replace", d, 32'h00C);
    chk("R12 after", {pslew[5], ppen[5], ppup[5], pana[5]}, 4'b0110);
    bus_wr(10'h014, 2'd2, 32'h0);
  endtask

  task automatic t_data;
    logic [31:0] d;
    bus_wr(10'h100, 2'd2, 32'hA5C3_0F96); set_byte(0, 8'hA5); set_byte(1, 8'hC3); set_byte(2, 8'h0F); set_byte(3, 8'h96);
    bus_wr(10'h104, 2'd3, 32'h1234_8E71); set_byte(4, 8'h12); set_byte(5, 8'h34); set_byte(6, 8'h8E); set_byte(7, 8'h71);
    chk("R7 pad order", pout, exp_dout);
    bus_rd(10'h100, 2'd2, d); chk("R7 word0", d, eword(exp_dout, 0));
    bus_rd(10'h104, 2'd2, d); chk("R7 word1", d, eword(exp_dout, 4));
    bus_rd(10'h102, 2'd1, d); chk("R8 half2", d, {16'h0, ebyte(exp_dout, 2), ebyte(exp_dout, 3)});
    bus_rd(10'h106, 2'd1, d); chk("R8 half6", d, 32'h8E71);
    bus_rd(10'h105, 2'd0, d); chk("R8 byte5", d, 32'h34);
    bus_rd(10'h103, 2'd1, d); chk("R8 half misaligned", d, 32'h0F96);
    bus_wr(10'h106, 2'd0, 32'hFFFF_FF3C); set_byte(6, 8'h3C);
    bus_rd(10'h104, 2'd2, d); chk("R8 byte write", d, 32'h1234_3C71);
    bus_wr(10'h101, 2'd1, 32'h0000_6B2D); set_byte(0, 8'h6B); set_byte(1, 8'h2D);
    bus_rd(10'h100, 2'd2, d); chk("R8 half write", d, eword(exp_dout, 0));
    chk("R3 gpio out", pout, exp_dout);
  endtask

  task automatic t_gpio;
    bus_wr(10'h028, 2'd2, 32'h40);
    chk("R3 oe on", poe[10], 1);
    chk("R3 out", pout[10], exp_dout[10]);
    chk("R3 others off", poe & ~(64'd1 << 10), '0);
    bus_wr(10'h028, 2'd2, 32'h0);
  endtask

  task automatic t_alt;
    bus_wr(10'h050, 2'd2, 32'h100);
    alt_out[20*NA+0] = 1; alt_oe[20*NA+0] = 1;
    alt_out[20*NA+1] = 0; alt_oe[20*NA+1] = 1;
    alt_out[20*NA+2] = 1; alt_oe[20*NA+2] = 0;
    #1; chk("R4 fsel2 out", pout[20], 0); chk("R4 fsel2 oe", poe[20], 1);
    alt_out[20*NA+1] = 1; #1; chk("R4 fsel2 follow", pout[20], 1);
    bus_wr(10'h050, 2'd2, 32'h180);
    chk("R4 fsel3", {pout[20], poe[20]}, 2'b10);
    bus_wr(10'h050, 2'd2, 32'h0);
    chk("R4 back gpio", {pout[20], poe[20]}, {exp_dout[20], 1'b0});
    alt_out = '0; alt_oe = '0;
  endtask

  task automatic t_od;
    bus_wr(10'h078, 2'd2, 32'h41);
    bus_wr(10'h103, 2'd0, 32'h02); set_byte(3, 8'h02);
    chk("R5 release", {pout[30], poe[30]}, 2'b00);
    bus_wr(10'h103, 2'd0, 32'h00); set_byte(3, 8'h00);
    chk("R5 drive low", {pout[30], poe[30]}, 2'b01);
    bus_wr(10'h078, 2'd2, 32'h0);
  endtask

  task automatic t_safe;
    bus_wr(10'h0A0, 2'd2, 32'h60);
    bus_wr(10'h0A4, 2'd2, 32'h40);
    bus_wr(10'h0A8, 2'd2, 32'hA0);
    alt_oe[42*NA+0] = 1;
    #1; chk("R6 before", poe[42:40], 3'b111);
    safe = 1; #1;
    chk("R6 safe", poe[42:40], 3'b010);
    safe = 0; #1;
    chk("R6 release", poe[42:40], 3'b111);
    alt_oe = '0;
    bus_wr(10'h0A0, 2'd2, 0); bus_wr(10'h0A4, 2'd2, 0); bus_wr(10'h0A8, 2'd2, 0);
  endtask

  task automatic t_din;
    logic [31:0] d0, d1, d2;
    @(negedge clk); pad_in = 64'hDEAD_BEEF_0123_4567;
    repeat (3) @(negedge clk);
    bus_rd(10'h200, 2'd2, d0); chk("R7 din word0", d0, eword(pad_in, 0));
    bus_wr(10'h200, 2'd2, 32'hFFFF_FFFF);
    bus_rd(10'h200, 2'd2, d0); chk("R9 din ignored", d0, eword(pad_in, 0));
    bus_rd(10'h100, 2'd2, d0); chk("R9 dout untouched", d0, eword(exp_dout, 0));
    // change at a negedge, then three back-to-back reads
    @(negedge clk);
    pad_in = 64'h5A5A_0000_FFFF_C3C3;
    req = 1; we = 0; addr = 10'h204; size = 2'd2;
    @(negedge clk); d0 = rdata;
    @(negedge clk); d1 = rdata;
    @(negedge clk); d2 = rdata; req = 0;
    chk("R10 edge1 old", d0, 32'h0123_4567 == 0 ? 0 : eword(64'hDEAD_BEEF_0123_4567, 4));
    chk("R10 edge2 old", d1, eword(64'hDEAD_BEEF_0123_4567, 4));
    chk("R10 edge3 new", d2, eword(pad_in, 4));
  endtask

  task automatic t_hold;
    logic [31:0] d;
    bus_rd(10'h104, 2'd2, d);
    bus_wr(10'h104, 2'd2, 32'hCAFE_0001); set_byte(4, 8'hCA); set_byte(5, 8'hFE); set_byte(6, 8'h00); set_byte(7, 8'h01);
    @(negedge clk); pad_in = ~pad_in;
    repeat (3) @(negedge clk);
    chk("R11 hold", rdata, d);
    bus_rd(10'h104, 2'd2, d); chk("R11 update", d, 32'hCAFE_0001);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_data();
    t_gpio();
    t_alt();
    t_od();
    t_safe();
    t_din();
    t_hold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule